// File: doc/BRIEF.md
# Nonvolatile Byte Store Access Controller

This block sits between an 8-bit processor register bus and a small nonvolatile byte array, which is modelled here as a plain byte memory. Software sees three registers: an address register, a data register and a control register. The control register carries a read strobe and a write-enable bit. Setting the read strobe copies the addressed byte into the data register in one access. Setting the write-enable bit captures the address and data and starts a programming cycle. That cycle lasts a fixed number of ticks of a separate calibrated oscillator, and hardware clears the bit when it ends. Software polls the bit to learn when the write has completed.

Each accepted access raises a processor stall output for a fixed number of clock cycles: two after a write start and four after a read. While a write is programming, the address is frozen and read requests are dropped, so the byte being programmed cannot be disturbed. The register bus has no back-pressure: an access is taken in the cycle `bus_en` is high. The stall output is the only flow control, and the processor must not drive the bus while the stall output is high.

Top module: `nvm_access_ctrl`

## Requirements
- R1: After reset the address, data and control registers all read zero, the busy bit is clear and `cpu_stall` is low.
- R2: A bus write to offset 2 with bit 1 set, made while idle, captures the current address and data. From the next cycle, bit 1 of offset 2 reads 1. It stays 1 until exactly PROG_TICKS oscillator ticks have been counted. It then clears, and in the same cycle the captured byte is stored at the captured address.
- R3: An accepted write start holds `cpu_stall` high for exactly 2 cycles, beginning the cycle after the access.
- R4: A bus write to offset 2 with bit 0 set, made while idle, loads the data register from the array at the current address on the next clock edge. Bit 0 of offset 2 always reads 0.
- R5: An accepted read holds `cpu_stall` high for exactly 4 cycles, beginning the cycle after the access.
- R6: While a write is programming, a read request leaves the data register unchanged and raises no stall.
- R7: While a write is programming, writes to offset 0 are ignored and the address register keeps its value.
- R8: `osc_tick` is synchronized into the clock domain and each rising edge counts as one tick. Ticks arriving while idle are not counted, and the count starts from zero at every write start.
- R9: If bits 0 and 1 are both set in one control write while idle, the write starts (with its 2-cycle stall) and the read is ignored.
- R10: While a write is programming, a control write cannot clear the busy bit. Setting bit 1 again does not restart the count and raises no stall.
- R11: Register offsets are 0 for address, 1 for data, 2 for control and 3 unused. Offset 3 reads zero and writes to it have no effect. The data register stays writable while busy, but the byte stored is the one captured at the write start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access in this cycle |
| bus_we | input | 1 | Access is a write when high |
| bus_sel | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the register at `bus_sel` (combinational) |
| osc_tick | input | 1 | Calibrated oscillator tick, asynchronous to `clk` |
| cpu_stall | output | 1 | Processor stall request |

## Verification
The assertions assume that the processor honours the stall: `bus_en` is never high while `cpu_stall` is high. This assumption is itself checked as a property. The stall-length and address-hold properties depend on it, since a new access during a stall would reload the stall counter. The bench waits for `cpu_stall` to fall before every access. It holds each oscillator tick high and then low for two clock cycles, so the synchronizer sees every edge. It reads memory only at addresses it has already programmed, because the array has no reset value.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int CTRL_RD_BIT = 0;
  localparam int CTRL_WR_BIT = 1;
endpackage

// File: rtl/nvm_tick_sync.sv
module nvm_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic tick_pulse
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] chain_q;

  genvar g;
  generate
    for (g = 0; g <= STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign tick_pulse = chain_q[STAGES-1] & ~chain_q[STAGES];

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_pulse |=> !tick_pulse); // R8
endmodule

// File: rtl/nvm_prog_timer.sv
module nvm_prog_timer #(
  parameter int PROG_TICKS = 26368
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(PROG_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(PROG_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign done = busy_q & tick & (cnt_q == LAST);
  assign busy = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q && tick) begin
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R2
  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tick) |=> $stable(cnt_q)); // R8
  AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (cnt_q == '0)); // R8
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q); // R2
endmodule

// File: rtl/nvm_stall_gen.sv
module nvm_stall_gen #(
  parameter int RD_CYC = 4,
  parameter int WR_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_rd,
  input  logic start_wr,
  output logic stall
);
  localparam int MAXC = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
  localparam int SW   = $clog2(MAXC + 1);
  localparam logic [SW-1:0] RD_LD = SW'(RD_CYC);
  localparam logic [SW-1:0] WR_LD = SW'(WR_CYC);
  localparam logic [SW-1:0] MAX_LD = SW'(MAXC);

  logic [SW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               left_q <= '0;
    else if (start_wr)        left_q <= WR_LD;
    else if (start_rd)        left_q <= RD_LD;
    else if (left_q != '0)    left_q <= left_q - 1'b1;
  end

  assign stall = (left_q != '0);

  AST_STALL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    left_q <= MAX_LD); // R5
  AST_STALL_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !start_rd && !start_wr) |=> (left_q < $past(left_q))); // R3
endmodule

// File: rtl/nvm_byte_array.sv
module nvm_byte_array #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/nvm_access_ctrl.sv
module nvm_access_ctrl #(
  parameter int AW           = 8,
  parameter int DW           = 8,
  parameter int PROG_TICKS   = 26368,
  parameter int RD_STALL_CYC = 4,
  parameter int WR_STALL_CYC = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [1:0]    bus_sel,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          osc_tick,
  output logic          cpu_stall
);
  import nvm_pkg::*;

  logic [AW-1:0] addr_q, pend_addr_q;
  logic [DW-1:0] data_q, pend_data_q;
  logic [DW-1:0] arr_rdata;
  logic          tick_pulse, busy, done;
  logic          wr_acc, ctrl_hit, req_wr, req_rd, start_wr, start_rd;
  reg_sel_e      sel;

  assign sel      = reg_sel_e'(bus_sel);
  assign wr_acc   = bus_en & bus_we;
  assign ctrl_hit = wr_acc & (sel == SEL_CTRL);
  assign req_wr   = ctrl_hit & bus_wdata[CTRL_WR_BIT];
  assign req_rd   = ctrl_hit & bus_wdata[CTRL_RD_BIT];
  assign start_wr = req_wr & ~busy;
  assign start_rd = req_rd & ~req_wr & ~busy;

  nvm_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(osc_tick), .tick_pulse(tick_pulse)
  );

  nvm_prog_timer #(.PROG_TICKS(PROG_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start_wr), .tick(tick_pulse),
    .busy(busy), .done(done)
  );

  nvm_stall_gen #(.RD_CYC(RD_STALL_CYC), .WR_CYC(WR_STALL_CYC)) u_stall (
    .clk(clk), .rst_n(rst_n), .start_rd(start_rd), .start_wr(start_wr),
    .stall(cpu_stall)
  );

  nvm_byte_array #(.AW(AW), .DW(DW)) u_array (
    .clk(clk), .we(done), .waddr(pend_addr_q), .wdata(pend_data_q),
    .raddr(addr_q), .rdata(arr_rdata)
  );

  // Address register: frozen while programming
  always_ff @(posedge clk) begin
    if (!rst_n)                                   addr_q <= '0;
    else if (wr_acc && sel == SEL_ADDR && !busy)  addr_q <= bus_wdata[AW-1:0];
  end

  // Data register: read result or software write
  always_ff @(posedge clk) begin
    if (!rst_n)                           data_q <= '0;
    else if (start_rd)                    data_q <= arr_rdata;
    else if (wr_acc && sel == SEL_DATA)   data_q <= bus_wdata;
  end

  // Commit buffer captured at write start
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_addr_q <= '0;
      pend_data_q <= '0;
    end else if (start_wr) begin
      pend_addr_q <= addr_q;
      pend_data_q <= data_q;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (sel)
      SEL_ADDR: bus_rdata[AW-1:0] = addr_q;
      SEL_DATA: bus_rdata = data_q;
      SEL_CTRL: bus_rdata[CTRL_WR_BIT] = busy;
      default:  bus_rdata = '0;
    endcase
  end

  AST_NO_BUS_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall |-> !bus_en); // R3
  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |=> busy); // R2
  AST_WR_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |=> cpu_stall); // R3
  AST_RD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    start_rd |=> cpu_stall); // R5
  AST_ADDR_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(addr_q)); // R7
  AST_RD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_rd && !(wr_acc && sel == SEL_DATA)) |=> $stable(data_q)); // R6
  AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(pend_addr_q) && $stable(pend_data_q)); // R11
  AST_BOTH_WR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && req_rd && !busy) |=> $stable(data_q) && busy); // R9
endmodule

// File: tb/nvm_access_ctrl_tb.sv
module nvm_access_ctrl_tb_top;
  localparam int PT = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_en = 1'b0, bus_we = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       osc_tick = 1'b0;
  logic       cpu_stall;
  int n_vec = 0, n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  nvm_access_ctrl #(.PROG_TICKS(PT)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .osc_tick(osc_tick), .cpu_stall(cpu_stall)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) ^ 8'h5A);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [1:0] s, output logic [7:0] v);
    @(negedge clk);
    bus_sel = s;
    #1 v = bus_rdata;
  endtask

  task automatic wr_reg(input logic [1:0] s, input logic [7:0] v);
    @(negedge clk);
    while (cpu_stall) @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_sel = s; bus_wdata = v;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  // called right after wr_reg, at the first negedge after the access edge
  task automatic stall_chk(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      chk(req, {7'd0, cpu_stall}, 8'd1);
      @(negedge clk);
    end
    chk(req, {7'd0, cpu_stall}, 8'd0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) osc_tick = 1'b1;
      @(negedge clk);
      @(negedge clk) osc_tick = 1'b0;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic busy_chk(input string req, input logic exp);
    logic [7:0] v;
    rd_reg(2'd2, v);
    chk(req, v, {6'd0, exp, 1'b0});
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_reg(2'd0, v); chk("R1 addr", v, 8'h00);
    rd_reg(2'd1, v); chk("R1 data", v, 8'h00);
    rd_reg(2'd2, v); chk("R1 ctrl", v, 8'h00);
    chk("R1 stall", {7'd0, cpu_stall}, 8'd0);

    // R8 ticks while idle are not counted
    ticks(3);

    // R2/R3 sweep every address
    for (int a = 0; a < 256; a++) begin
      wr_reg(2'd0, 8'(a));
      wr_reg(2'd1, pat(a));
      wr_reg(2'd2, 8'h02);
      stall_chk("R3 write stall", 2);
      busy_chk("R2 busy set", 1'b1);
      ticks(PT - 1);
      busy_chk("R2 busy before last tick", 1'b1);
      ticks(1);
      busy_chk("R2 busy cleared", 1'b0);
    end

    // R4/R5 read sweep
    for (int a = 0; a < 256; a++) begin
      wr_reg(2'd0, 8'(a));
      wr_reg(2'd2, 8'h01);
      stall_chk("R5 read stall", 4);
      rd_reg(2'd1, v); chk("R4 read data", v, pat(a));
      rd_reg(2'd2, v); chk("R4 strobe reads zero", v, 8'h00);
    end

    // R6 R7 R10 R11 during a write
    wr_reg(2'd0, 8'h10);
    wr_reg(2'd1, 8'hC3);
    wr_reg(2'd2, 8'h02);
    stall_chk("R3 write stall", 2);
    wr_reg(2'd0, 8'h77);
    rd_reg(2'd0, v); chk("R7 addr held", v, 8'h10);
    wr_reg(2'd1, 8'hEE);
    rd_reg(2'd1, v); chk("R11 data writable", v, 8'hEE);
    wr_reg(2'd2, 8'h01);
    stall_chk("R6 no read stall", 0);
    rd_reg(2'd1, v); chk("R6 data unchanged", v, 8'hEE);
    wr_reg(2'd2, 8'h00);
    busy_chk("R10 no software clear", 1'b1);
    ticks(3);
    wr_reg(2'd2, 8'h02);
    stall_chk("R10 no restart stall", 0);
    ticks(PT - 4);
    busy_chk("R10 count not restarted", 1'b1);
    ticks(1);
    busy_chk("R10 done at original count", 1'b0);
    wr_reg(2'd2, 8'h01);
    stall_chk("R5 read stall", 4);
    rd_reg(2'd1, v); chk("R11 captured data stored", v, 8'hC3);

    // R9 both bits
    wr_reg(2'd0, 8'h20);
    wr_reg(2'd1, 8'h11);
    wr_reg(2'd2, 8'h03);
    stall_chk("R9 write stall", 2);
    busy_chk("R9 write started", 1'b1);
    rd_reg(2'd1, v); chk("R9 read ignored", v, 8'h11);
    ticks(PT);
    busy_chk("R9 write done", 1'b0);
    wr_reg(2'd1, 8'h00);
    wr_reg(2'd2, 8'h01);
    stall_chk("R5 read stall", 4);
    rd_reg(2'd1, v); chk("R9 byte stored", v, 8'h11);

    // R11 unused offset
    wr_reg(2'd3, 8'hFF);
    rd_reg(2'd3, v); chk("R11 offset 3 zero", v, 8'h00);
    rd_reg(2'd0, v); chk("R11 addr untouched", v, 8'h20);
    rd_reg(2'd1, v); chk("R11 data untouched", v, 8'h11);
    busy_chk("R11 ctrl untouched", 1'b0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule